// File: doc/BRIEF.md
# Return-to-Zero Serial Word Receiver

This block is a single receive channel for a two-wire return-to-zero avionics data bus. It takes the A and B line states, already converted to logic levels from the differential bus. It samples them once per cycle of a fixed sampling clock, which is nominally 1 MHz. From these samples it recognises marks and nulls, collects up to 32 bits into a word, and detects the long null that separates two words.

When a word of the configured length arrives clean, the block holds it, records whether its parity is odd, and pulls an active-low ready flag low. A host reads the held word as two 16-bit halves through a read port that is active only while the active-low output enable is asserted. A select input chooses the half. Once both halves have been read, the ready flag is released.

Two control inputs set the configuration. One picks the bit rate: 10 samples per bit at the fast rate, or 80 at the slow rate. The other picks the word length: 25 or 32 bits.

Top module: `rz_word_receiver`

## Requirements
- R1: After reset `rdy_n` is high. It goes low after a word of the configured length has been received without an invalid symbol and closed by a word gap.
- R2: A word ends only when the line has been null for GAP samples in a row. GAP is 1.5 nominal bit times: 15 samples at the fast rate, 120 at the slow rate. Shorter nulls inside a word do not split it.
- R3: `rd_drive` is high, and `rd_data` may be non-zero, only while `rd_oe_n` is low. Otherwise `rd_data` is all zeros.
- R4: In the held word, bit k is the k-th received bit, counting from 0. With `half_sel` = 0 the port shows bits 15:0. With `half_sel` = 1 it shows bits 31:16.
- R5: Each sample is decoded from (A,B): (1,0) is a one mark, (0,1) is a zero mark, and (0,0) is null. A bit is taken each time a mark follows a null.
- R6: A sample with both A and B high aborts the word in progress. No ready flag is raised, and the previously held word is unchanged.
- R7: A word whose bit count differs from the configured length is discarded.
- R8: With `len_short` = 1, 25-bit words are accepted and held bits 31:25 read as zero. With `len_short` = 0, only 32-bit words are accepted.
- R9: `rate_slow` = 0 accepts bit periods of 9 to 11 samples. `rate_slow` = 1 accepts bit periods of 69 to 125 samples, which covers 14.5 down to 8 kbps at 1 MHz.
- R10: `par_ok` is high when the held word contains an odd number of one bits.
- R11: `rdy_n` stays low after only one half has been read. It returns high after both halves have been read, in either order.
- R12: A new valid word replaces the held word, keeps `rdy_n` low and forgets which halves were already read.
- R13: A reset in the middle of a word clears the partial bit count, so the bits that follow the reset do not form a valid word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, one line sample per cycle |
| rst | input | 1 | Synchronous active-high reset |
| line_a | input | 1 | Logic level of line A |
| line_b | input | 1 | Logic level of line B |
| rate_slow | input | 1 | 0: 10 samples per bit, 1: 80 samples per bit |
| len_short | input | 1 | 0: 32-bit words, 1: 25-bit words |
| half_sel | input | 1 | 0: low half, 1: high half of the held word |
| rd_oe_n | input | 1 | Active-low output enable of the read port |
| rd_data | output | 16 | Selected half of the held word |
| rd_drive | output | 1 | High while the port should be driven |
| rdy_n | output | 1 | Active-low word-ready flag |
| par_ok | output | 1 | Odd parity of the held word |

## Verification
The bench builds the block with its default parameters: 10 and 80 samples per bit, 32-bit words, and a 25-bit short length. With these values, both rate settings are reached at both ends of their tolerance windows in a few thousand cycles. Mid-word nulls of 14 and 16 samples are sent at the fast rate to probe the 15-sample gap threshold from either side. The 25-bit setting is exercised both with a matching word and with a 32-bit word that it must discard.

// File: rtl/rzr_pkg.sv
package rzr_pkg;

    // Symbol seen on the line pair, encoded as {A,B}
    typedef enum logic [1:0] {
        SYM_NULL = 2'b00,
        SYM_ZERO = 2'b01,
        SYM_ONE  = 2'b10,
        SYM_BAD  = 2'b11
    } line_sym_t;

    typedef struct packed {
        logic [31:0] bits;
        logic        par_ok;
    } held_word_t;

    function automatic line_sym_t decode_sym(input logic a, input logic b);
        return line_sym_t'({a, b});
    endfunction

    function automatic logic odd_ones(input logic [31:0] w);
        return ^w;
    endfunction

endpackage

// File: rtl/rzr_sampler.sv
module rzr_sampler
    import rzr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      line_a,
    input  logic      line_b,
    output line_sym_t sym,
    output logic      mark_start,
    output logic      bit_val
);
    line_sym_t sym_q, sym_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            sym_q    <= SYM_NULL;
            sym_prev <= SYM_NULL;
        end else begin
            sym_q    <= decode_sym(line_a, line_b);
            sym_prev <= sym_q;
        end
    end

    assign sym        = sym_q;
    assign mark_start = (sym_prev == SYM_NULL) && (sym_q == SYM_ONE || sym_q == SYM_ZERO);
    assign bit_val    = (sym_q == SYM_ONE);
endmodule

// File: rtl/rzr_framer.sv
module rzr_framer
    import rzr_pkg::*;
#(
    parameter int SPB_FAST   = 10,
    parameter int SPB_SLOW   = 80,
    parameter int WORD_BITS  = 32,
    parameter int SHORT_BITS = 25
) (
    input  logic                 clk,
    input  logic                 rst,
    input  line_sym_t            sym,
    input  logic                 mark_start,
    input  logic                 bit_val,
    input  logic                 rate_slow,
    input  logic                 len_short,
    output logic                 word_valid,
    output logic [WORD_BITS-1:0] word_bits
);
    localparam int GAP_FAST = (SPB_FAST * 3) / 2;
    localparam int GAP_SLOW = (SPB_SLOW * 3) / 2;
    localparam int CNT_W    = $clog2(GAP_SLOW + 1);
    localparam int BCNT_W   = $clog2(WORD_BITS + 2);
    localparam int IDX_W    = $clog2(WORD_BITS);
    localparam logic [CNT_W-1:0]  GAP_F_C  = CNT_W'(GAP_FAST);
    localparam logic [CNT_W-1:0]  GAP_S_C  = CNT_W'(GAP_SLOW);
    localparam logic [BCNT_W-1:0] FULL_C   = BCNT_W'(WORD_BITS);
    localparam logic [BCNT_W-1:0] SHORT_C  = BCNT_W'(SHORT_BITS);
    localparam logic [BCNT_W-1:0] OVER_C   = BCNT_W'(WORD_BITS + 1);

    logic [CNT_W-1:0]     null_cnt;
    logic [BCNT_W-1:0]    bit_cnt;
    logic [WORD_BITS-1:0] shreg;
    logic                 abort_q;
    logic [CNT_W-1:0]     gap_lim;
    logic [BCNT_W-1:0]    need;
    logic                 gap_hit;

    assign gap_lim = rate_slow ? GAP_S_C : GAP_F_C;
    assign need    = len_short ? SHORT_C : FULL_C;
    assign gap_hit = (sym == SYM_NULL) && (null_cnt == gap_lim - CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            null_cnt   <= '0;
            bit_cnt    <= '0;
            shreg      <= '0;
            abort_q    <= 1'b0;
            word_valid <= 1'b0;
            word_bits  <= '0;
        end else begin
            word_valid <= 1'b0;
            if (sym != SYM_NULL)
                null_cnt <= '0;
            else if (null_cnt < gap_lim)
                null_cnt <= null_cnt + CNT_W'(1);

            if (gap_hit) begin
                if (bit_cnt != '0 && !abort_q && bit_cnt == need) begin
                    word_valid <= 1'b1;
                    word_bits  <= shreg;
                end
                bit_cnt <= '0;
                shreg   <= '0;
                abort_q <= 1'b0;
            end else begin
                if (sym == SYM_BAD)
                    abort_q <= 1'b1;
                if (mark_start && bit_cnt < OVER_C) begin
                    if (bit_cnt < FULL_C)
                        shreg[bit_cnt[IDX_W-1:0]] <= bit_val;
                    bit_cnt <= bit_cnt + BCNT_W'(1);
                end
            end
        end
    end

    // R7
    bitcnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        bit_cnt <= OVER_C);

    // R2
    commit_after_gap_chk: assert property (@(posedge clk) disable iff (rst)
        word_valid |-> $past(sym == SYM_NULL));
endmodule

// File: rtl/rzr_holder.sv
module rzr_holder
    import rzr_pkg::*;
#(
    parameter int WORD_BITS = 32,
    parameter int HALF_W    = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 word_valid,
    input  logic [WORD_BITS-1:0] word_bits,
    input  logic                 rd_oe_n,
    input  logic                 half_sel,
    output logic [HALF_W-1:0]    rd_data,
    output logic                 rd_drive,
    output logic                 rdy_n,
    output logic                 par_ok
);
    held_word_t held;
    logic lo_seen, hi_seen, both_seen;

    assign both_seen = lo_seen && hi_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            held    <= '0;
            rdy_n   <= 1'b1;
            lo_seen <= 1'b0;
            hi_seen <= 1'b0;
        end else if (word_valid) begin
            held.bits   <= word_bits;
            held.par_ok <= odd_ones(word_bits);
            rdy_n       <= 1'b0;
            lo_seen     <= 1'b0;
            hi_seen     <= 1'b0;
        end else if (!rdy_n) begin
            if (both_seen) begin
                rdy_n   <= 1'b1;
                lo_seen <= 1'b0;
                hi_seen <= 1'b0;
            end else if (!rd_oe_n) begin
                if (half_sel) hi_seen <= 1'b1;
                else          lo_seen <= 1'b1;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        if (!rd_oe_n)
            rd_data = half_sel ? held.bits[WORD_BITS-1:HALF_W] : held.bits[HALF_W-1:0];
    end
    assign rd_drive = !rd_oe_n;
    assign par_ok   = held.par_ok;

    // R1
    done_sets_ready_chk: assert property (@(posedge clk) disable iff (rst)
        word_valid |=> !rdy_n);

    // R11
    ready_release_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rdy_n) |-> ($past(both_seen) || $past(rst)));
endmodule

// File: rtl/rz_word_receiver.sv
module rz_word_receiver
    import rzr_pkg::*;
#(
    parameter int SPB_FAST   = 10,
    parameter int SPB_SLOW   = 80,
    parameter int WORD_BITS  = 32,
    parameter int SHORT_BITS = 25
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        line_a,
    input  logic        line_b,
    input  logic        rate_slow,
    input  logic        len_short,
    input  logic        half_sel,
    input  logic        rd_oe_n,
    output logic [15:0] rd_data,
    output logic        rd_drive,
    output logic        rdy_n,
    output logic        par_ok
);
    localparam int HALF_W = WORD_BITS / 2;

    line_sym_t            sym;
    logic                 mark_start, bit_val, word_valid;
    logic [WORD_BITS-1:0] word_bits;

    rzr_sampler u_samp (
        .clk(clk), .rst(rst), .line_a(line_a), .line_b(line_b),
        .sym(sym), .mark_start(mark_start), .bit_val(bit_val)
    );

    rzr_framer #(
        .SPB_FAST(SPB_FAST), .SPB_SLOW(SPB_SLOW),
        .WORD_BITS(WORD_BITS), .SHORT_BITS(SHORT_BITS)
    ) u_frm (
        .clk(clk), .rst(rst), .sym(sym), .mark_start(mark_start),
        .bit_val(bit_val), .rate_slow(rate_slow), .len_short(len_short),
        .word_valid(word_valid), .word_bits(word_bits)
    );

    rzr_holder #(.WORD_BITS(WORD_BITS), .HALF_W(HALF_W)) u_hold (
        .clk(clk), .rst(rst), .word_valid(word_valid), .word_bits(word_bits),
        .rd_oe_n(rd_oe_n), .half_sel(half_sel), .rd_data(rd_data),
        .rd_drive(rd_drive), .rdy_n(rdy_n), .par_ok(par_ok)
    );

    // R3
    quiet_port_chk: assert property (@(posedge clk) disable iff (rst)
        rd_oe_n |-> (rd_data == '0 && !rd_drive));
endmodule

// File: tb/rz_word_receiver_tb.sv
module rz_word_receiver_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic line_a = 1'b0, line_b = 1'b0;
    logic rate_slow = 1'b0, len_short = 1'b0, half_sel = 1'b0, rd_oe_n = 1'b1;
    logic [15:0] rd_data;
    logic rd_drive, rdy_n, par_ok;
    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    rz_word_receiver dut_i (
        .clk(clk), .rst(rst), .line_a(line_a), .line_b(line_b),
        .rate_slow(rate_slow), .len_short(len_short), .half_sel(half_sel),
        .rd_oe_n(rd_oe_n), .rd_data(rd_data), .rd_drive(rd_drive),
        .rdy_n(rdy_n), .par_ok(par_ok)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send_bits(input logic [31:0] w, input int first, input int last,
                             input int mk, input int nl, input int bad_at,
                             input int split_at, input int split_len);
        for (int i = first; i <= last; i++) begin
            @(negedge clk);
            if (i == bad_at) {line_a, line_b} = 2'b11;
            else             {line_a, line_b} = w[i] ? 2'b10 : 2'b01;
            repeat (mk - 1) @(negedge clk);
            @(negedge clk);
            {line_a, line_b} = 2'b00;
            repeat (((i == split_at) ? split_len : nl) - 1) @(negedge clk);
        end
    endtask

    task automatic send_word(input logic [31:0] w, input int n, input int mk, input int nl,
                             input int bad_at);
        send_bits(w, 0, n - 1, mk, nl, bad_at, -1, 0);
        repeat (200) @(negedge clk);
    endtask

    task automatic read_half(input logic sel, output logic [15:0] d);
        @(negedge clk);
        half_sel = sel;
        rd_oe_n  = 1'b0;
        #1 d = rd_data;
        @(negedge clk);
        rd_oe_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic read_word(output logic [31:0] w);
        logic [15:0] lo, hi;
        read_half(1'b0, lo);
        read_half(1'b1, hi);
        w = {hi, lo};
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R1 reset ready", {31'b0, rdy_n}, 32'd1);
        check("R3 idle port", {15'b0, rd_drive, rd_data}, 32'd0);
    endtask

    task automatic t_basic;
        logic [15:0] d;
        logic [31:0] w = 32'hA5C3_1E69;
        send_word(w, 32, 5, 5, -1);
        check("R1 ready after word", {31'b0, rdy_n}, 32'd0);
        check("R10 parity", {31'b0, par_ok}, {31'b0, ^w});
        @(negedge clk); half_sel = 1'b0; rd_oe_n = 1'b0;
        #1 check("R3 drive while enabled", {31'b0, rd_drive}, 32'd1);
        rd_oe_n = 1'b1;
        read_half(1'b0, d);
        check("R4 low half", {16'b0, d}, {16'b0, w[15:0]});
        check("R11 ready held after one half", {31'b0, rdy_n}, 32'd0);
        read_half(1'b1, d);
        check("R4 high half", {16'b0, d}, {16'b0, w[31:16]});
        check("R11 ready released", {31'b0, rdy_n}, 32'd1);
    endtask

    task automatic t_parity_even;
        logic [31:0] r;
        send_word(32'h0000_0003, 32, 5, 5, -1);
        check("R10 even parity", {31'b0, par_ok}, 32'd0);
        read_word(r);
        check("R5 decode zeros and ones", r, 32'h0000_0003);
    endtask

    task automatic t_rates;
        logic [31:0] r;
        send_word(32'h1234_5678, 32, 5, 4, -1);
        read_word(r);
        check("R9 fast 9-sample bits", r, 32'h1234_5678);
        send_word(32'h8765_4321, 32, 6, 5, -1);
        read_word(r);
        check("R9 fast 11-sample bits", r, 32'h8765_4321);
        rate_slow = 1'b1;
        send_word(32'hDEAD_BEEF, 32, 35, 34, -1);
        read_word(r);
        check("R9 slow 69-sample bits", r, 32'hDEAD_BEEF);
        send_word(32'h0F0F_F0F0, 32, 63, 62, -1);
        read_word(r);
        check("R9 slow 125-sample bits", r, 32'h0F0F_F0F0);
        rate_slow = 1'b0;
    endtask

    task automatic t_gap;
        logic [31:0] r;
        send_bits(32'hCAFE_0123, 0, 31, 5, 5, -1, 15, 14);
        repeat (200) @(negedge clk);
        check("R2 short null keeps word", {31'b0, rdy_n}, 32'd0);
        read_word(r);
        check("R2 word intact", r, 32'hCAFE_0123);
        send_bits(32'h1111_2222, 0, 31, 5, 5, -1, 15, 16);
        repeat (200) @(negedge clk);
        check("R2 long null splits word", {31'b0, rdy_n}, 32'd1);
    endtask

    task automatic t_length;
        logic [31:0] r;
        send_word(32'h7777_7777, 31, 5, 5, -1);
        check("R7 31-bit word discarded", {31'b0, rdy_n}, 32'd1);
        len_short = 1'b1;
        send_word(32'hFFAB_CDEF, 25, 5, 5, -1);
        check("R8 25-bit ready", {31'b0, rdy_n}, 32'd0);
        read_word(r);
        check("R8 25-bit value", r, 32'h01AB_CDEF);
        send_word(32'h2468_ACE0, 32, 5, 5, -1);
        check("R8 32-bit word rejected in short mode", {31'b0, rdy_n}, 32'd1);
        len_short = 1'b0;
    endtask

    task automatic t_bad;
        logic [31:0] r;
        send_word(32'h5555_AAAA, 32, 5, 5, -1);
        read_word(r);
        send_word(32'h3333_CCCC, 32, 5, 5, 10);
        check("R6 aborted word no ready", {31'b0, rdy_n}, 32'd1);
        read_word(r);
        check("R6 held word kept", r, 32'h5555_AAAA);
    endtask

    task automatic t_overwrite;
        logic [15:0] d;
        send_word(32'h0102_0304, 32, 5, 5, -1);
        read_half(1'b0, d);
        send_word(32'hA0B0_C0D0, 32, 5, 5, -1);
        check("R12 ready after new word", {31'b0, rdy_n}, 32'd0);
        read_half(1'b1, d);
        check("R12 new high half", {16'b0, d}, 32'h0000_A0B0);
        check("R12 read tracking reset", {31'b0, rdy_n}, 32'd0);
        read_half(1'b0, d);
        check("R12 new low half", {16'b0, d}, 32'h0000_C0D0);
        check("R11 released after both", {31'b0, rdy_n}, 32'd1);
    endtask

    task automatic t_reset_mid;
        send_bits(32'h9999_9999, 0, 9, 5, 5, -1, -1, 0);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        send_bits(32'h9999_9999, 10, 31, 5, 5, -1, -1, 0);
        repeat (200) @(negedge clk);
        check("R13 partial word cleared", {31'b0, rdy_n}, 32'd1);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_basic();
        t_parity_even();
        t_rates();
        t_gap();
        t_length();
        t_bad();
        t_overwrite();
        t_reset_mid();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule